// File: doc/BRIEF.md
# Dual-Clock Configuration Register Port

This block is the host-facing configuration store for a four-channel engine. A host drives a 7-bit address, a 16-bit write value and a write strobe, and reads back a 16-bit value, all in its own host clock domain. The address space holds four channel windows and one control window at the top. Every mapped word has two copies. The host-side copy takes the written value on the host clock. The core-side copy, which is the copy that reads return, receives that value through a toggle handshake that crosses the two clock domains. The core copy changes on the fourth core clock edge after the host edge that accepted the write.

While its transfer is in flight, each word reports busy. A second write to a busy word is not dropped. It waits in a per-word holding slot, and if several writes arrive the newest one is kept. The slot empties into the host copy once the transfer completes. The control window also carries an indirect path into a paged table of 3 x 256 words. A data word is loaded first, and a command word then names the access type, the page and the offset. The result of an indirect read is returned at its own read-only address. The block has two resets. An asynchronous hard reset clears both copies. A soft reset, taken in the core domain, clears only the core copies and the indirect result.

Top module: `cfgif_host_regs`

## Requirements
- R1: Channel n (n = 0..3) owns addresses n*0x20 + 0x00 to n*0x20 + 0x17, and the control window is 0x78 to 0x7F. Addresses 0x18-0x1F, 0x38-0x3F and 0x58-0x5F are unmapped. A read of an unmapped address returns 0x0000. A write to an unmapped address changes nothing and raises no busy.
- R2: After the hard reset is released, every address reads 0x0000 and busy is low.
- R3: A written value becomes readable at the fourth core clock edge after the host edge that accepted the write. Before that edge, reads return the previous value.
- R4: Busy for the addressed word is high from the host cycle after a write. It stays high until the core's acknowledge has crossed back, then falls, which at equal clock periods is the sixth host cycle.
- R5: A write to one address does not raise busy on other addresses. Writes to different addresses on consecutive host cycles each land with their own value.
- R6: A write to a word that is busy is held and applied after the transfer in flight completes. Of several held writes, the last one wins. Busy stays high until the held value has been transferred.
- R7: A soft reset clears every readable word and the indirect read result to 0x0000.
- R8: The indirect command lives at 0x78 and the indirect write data at 0x79. In the command, bit 15 = 1 selects a read and 0 selects a write. Bits 9:8 select the page, bits 7:0 select the offset, and bits 14:10 are ignored. The command runs when its write reaches the core copy.
- R9: An indirect write stores the core copy of 0x79 at the selected page and offset. A later indirect read of that location places the stored value in the result word at 0x7A.
- R10: Page 3 is not backed by storage. An indirect write to page 3 stores nothing and leaves pages 0 to 2 unchanged. An indirect read of page 3 returns 0x0000.
- R11: Address 0x7A is read-only. A write to it is ignored and the indirect result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host-side clock; host copies, holding slots and the write strobe run on it |
| coreClk | input | 1 | Core clock; core copies and the indirect table run on it |
| hardRstN | input | 1 | Asynchronous active-low hard reset for both domains |
| softRst | input | 1 | Active-high soft reset, synchronous to coreClk, clears the core copies |
| hostWr | input | 1 | Write strobe, sampled on hostClk |
| hostAddr | input | 7 | Word address for both read and write |
| hostWrData | input | 16 | Write value |
| hostRdData | output | 16 | Core copy of the addressed word, combinational from hostAddr |
| hostBusy | output | 1 | High while the addressed word has a transfer in flight or a held write |

## Verification
The bench builds the block with its default package values: four channels of 24 words in 32-word windows, an 8-word control window, and three 256-word indirect pages. Both clocks run at the same period with a fixed 3 ns phase offset. That offset makes the crossing latency deterministic, so the bench can check the exact edge on which readback changes and the exact cycle on which busy falls. The default map brings every unmapped gap, the read-only result word and the storage-free fourth page within reach of the reference model. This lets the bench sweep all 128 addresses after each phase.

// File: rtl/cfgif_pkg.sv
`timescale 1ns/1ps
package cfgif_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 7;
  localparam int NUM_CH     = 4;
  localparam int CH_WORDS   = 24;
  localparam int WIN_STRIDE = 32;
  localparam int CTRL_WORDS = 8;
  localparam int CMD_OFF    = 0;
  localparam int WDATA_OFF  = 1;
  localparam int RESULT_OFF = 2;
  localparam int PAGE_WORDS = 256;
  localparam int NUM_PAGES  = 3;
  localparam int SYNC_N     = 2;

  localparam int CH_TOTAL  = NUM_CH * CH_WORDS;
  localparam int NUM_REGS  = CH_TOTAL + CTRL_WORDS;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int CTRL_BASE = NUM_CH * WIN_STRIDE - CTRL_WORDS;
  localparam int CMD_IDX   = CH_TOTAL + CMD_OFF;
  localparam int WDATA_IDX = CH_TOTAL + WDATA_OFF;
  localparam int OFF_W     = $clog2(PAGE_WORDS);
  localparam int PAGE_W    = $clog2(NUM_PAGES + 1);
  localparam int RD_BIT    = DATA_W - 1;
  localparam int MEM_WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int MEM_AW    = $clog2(MEM_WORDS);

  // Strobes from the host-side decoder to the register bank
  typedef struct packed {
    logic             wrEn;      // write to a storable word
    logic             rdHit;     // address maps to a stored word
    logic             rdResult;  // address is the indirect result word
    logic [IDX_W-1:0] idx;       // flat word index
  } strobe_t;

  function automatic strobe_t decodeAddr(input logic [ADDR_W-1:0] addr, input logic wr);
    strobe_t s;
    int ai;
    int off;
    s  = '0;
    ai = int'(addr);
    if (ai >= CTRL_BASE) begin
      off = ai - CTRL_BASE;
      if (off == RESULT_OFF) begin
        s.rdResult = 1'b1;
      end else begin
        s.rdHit = 1'b1;
        s.wrEn  = wr;
        s.idx   = IDX_W'(CH_TOTAL + off);
      end
    end else begin
      off = ai % WIN_STRIDE;
      if (off < CH_WORDS) begin
        s.rdHit = 1'b1;
        s.wrEn  = wr;
        s.idx   = IDX_W'((ai / WIN_STRIDE) * CH_WORDS + off);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/cfgif_host_ctrl.sv
`timescale 1ns/1ps
module cfgif_host_ctrl
  import cfgif_pkg::*;
(
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  output strobe_t           strb
);
  // Address map decode into strobes for the bank
  always_comb begin
    strb = decodeAddr(hostAddr, hostWr);
  end
endmodule

// File: rtl/cfgif_reg_bank.sv
`timescale 1ns/1ps
module cfgif_reg_bank
  import cfgif_pkg::*;
(
  input  logic                             hostClk,
  input  logic                             coreClk,
  input  logic                             hardRstN,
  input  logic                             softRst,
  input  strobe_t                          strb,
  input  logic [DATA_W-1:0]                wrData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  slaveFlat,
  output logic                             cmdLoad,
  output logic                             hostBusy
);
  logic [NUM_REGS-1:0] busyV;
  logic [NUM_REGS-1:0] loadV;

  for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
    logic [DATA_W-1:0] masterR, holdR, slaveR;
    logic              holdV, reqTgl, ackTgl, seen, loadR;
    logic [SYNC_N-1:0] ackSync, reqSync;
    logic              wrHit, inflight;

    assign wrHit    = strb.wrEn && (strb.idx == IDX_W'(a));
    assign inflight = reqTgl ^ ackSync[SYNC_N-1];

    // Host side: master copy, holding slot, request toggle
    always_ff @(posedge hostClk or negedge hardRstN) begin
      if (!hardRstN) begin
        masterR <= '0;
        holdR   <= '0;
        holdV   <= 1'b0;
        reqTgl  <= 1'b0;
        ackSync <= '0;
      end else begin
        ackSync <= {ackSync[SYNC_N-2:0], ackTgl};
        if (wrHit) begin
          if (inflight) begin
            holdR <= wrData;
            holdV <= 1'b1;
          end else begin
            masterR <= wrData;
            reqTgl  <= ~reqTgl;
            holdV   <= 1'b0;
          end
        end else if (holdV && !inflight) begin
          masterR <= holdR;
          reqTgl  <= ~reqTgl;
          holdV   <= 1'b0;
        end
      end
    end

    // Core side: synchronize request, load slave, return acknowledge
    always_ff @(posedge coreClk or negedge hardRstN) begin
      if (!hardRstN) begin
        reqSync <= '0;
        seen    <= 1'b0;
        loadR   <= 1'b0;
        ackTgl  <= 1'b0;
        slaveR  <= '0;
      end else begin
        reqSync <= {reqSync[SYNC_N-2:0], reqTgl};
        seen    <= reqSync[SYNC_N-1];
        loadR   <= reqSync[SYNC_N-1] ^ seen;
        if (loadR) ackTgl <= ~ackTgl;
        if (softRst)    slaveR <= '0;
        else if (loadR) slaveR <= masterR;
      end
    end

    assign busyV[a]     = inflight | holdV;
    assign slaveFlat[a] = slaveR;
    assign loadV[a]     = loadR;

    // R6: master copy is frozen while its transfer is in flight
    p_master_frozen_r6: assert property (@(posedge hostClk) disable iff (!hardRstN)
      inflight |=> $stable(masterR));
    // R4: an accepted write shows busy on the next host cycle
    p_busy_after_wr_r4: assert property (@(posedge hostClk) disable iff (!hardRstN)
      wrHit |=> busyV[a]);
    // R3: one transfer produces exactly one load pulse
    p_single_load_r3: assert property (@(posedge coreClk) disable iff (!hardRstN)
      loadR |=> !loadR);
    // R7: soft reset leaves the core copy at zero
    p_soft_clear_r7: assert property (@(posedge coreClk) disable iff (!hardRstN)
      softRst |=> (slaveR == '0));
  end

  assign cmdLoad  = loadV[CMD_IDX];
  assign hostBusy = strb.rdHit && busyV[strb.idx];

  logic unusedLoads;
  assign unusedLoads = ^loadV;
endmodule

// File: rtl/cfgif_indirect.sv
`timescale 1ns/1ps
module cfgif_indirect
  import cfgif_pkg::*;
(
  input  logic              coreClk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              cmdLoad,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic [DATA_W-1:0] dataWord,
  output logic [DATA_W-1:0] result
);
  logic              goR;
  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;
  logic              isRd, pageOk;
  logic [MEM_AW-1:0] memIdx;
  logic              unusedCmdBits;

  assign page   = cmdWord[OFF_W +: PAGE_W];
  assign off    = cmdWord[OFF_W-1:0];
  assign isRd   = cmdWord[RD_BIT];
  assign pageOk = int'(page) < NUM_PAGES;
  assign memIdx = MEM_AW'(int'(page) * PAGE_WORDS + int'(off));
  assign unusedCmdBits = ^cmdWord[RD_BIT-1:OFF_W+PAGE_W];

  // Command executes one core cycle after the command word lands
  always_ff @(posedge coreClk or negedge hardRstN) begin
    if (!hardRstN) goR <= 1'b0;
    else           goR <= cmdLoad;
  end

  always_ff @(posedge coreClk) begin
    if (goR && !isRd && pageOk) mem[memIdx] <= dataWord;
  end

  always_ff @(posedge coreClk or negedge hardRstN) begin
    if (!hardRstN)          result <= '0;
    else if (softRst)       result <= '0;
    else if (goR && isRd)   result <= pageOk ? mem[memIdx] : '0;
  end

  // R10: a read of the unbacked page yields zero
  p_page3_read_r10: assert property (@(posedge coreClk) disable iff (!hardRstN)
    (goR && isRd && !pageOk) |=> (result == '0));
endmodule

// File: rtl/cfgif_host_regs.sv
`timescale 1ns/1ps
module cfgif_host_regs
  import cfgif_pkg::*;
(
  input  logic              hostClk,
  input  logic              coreClk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostBusy
);
  localparam int RESULT_ADDR = CTRL_BASE + RESULT_OFF;

  strobe_t                         strb;
  logic [NUM_REGS-1:0][DATA_W-1:0] slaveFlat;
  logic                            cmdLoad;
  logic [DATA_W-1:0]               indResult;

  cfgif_host_ctrl u_ctrl (
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .strb     (strb)
  );

  cfgif_reg_bank u_bank (
    .hostClk   (hostClk),
    .coreClk   (coreClk),
    .hardRstN  (hardRstN),
    .softRst   (softRst),
    .strb      (strb),
    .wrData    (hostWrData),
    .slaveFlat (slaveFlat),
    .cmdLoad   (cmdLoad),
    .hostBusy  (hostBusy)
  );

  cfgif_indirect u_ind (
    .coreClk  (coreClk),
    .hardRstN (hardRstN),
    .softRst  (softRst),
    .cmdLoad  (cmdLoad),
    .cmdWord  (slaveFlat[CMD_IDX]),
    .dataWord (slaveFlat[WDATA_IDX]),
    .result   (indResult)
  );

  always_comb begin
    if (strb.rdResult)   hostRdData = indResult;
    else if (strb.rdHit) hostRdData = slaveFlat[strb.idx];
    else                 hostRdData = '0;
  end

  logic addrUndef;
  assign addrUndef = (int'(hostAddr) < CTRL_BASE) &&
                     ((int'(hostAddr) % WIN_STRIDE) >= CH_WORDS);

  // R1: unmapped writes never reach the bank
  p_undef_write_r1: assert property (@(posedge hostClk) disable iff (!hardRstN)
    (hostWr && addrUndef) |-> !strb.wrEn);
  // R1: unmapped reads return zero and no busy
  p_undef_read_r1: assert property (@(posedge hostClk) disable iff (!hardRstN)
    addrUndef |-> (hostRdData == '0 && !hostBusy));
  // R11: the result word is never written
  p_result_ro_r11: assert property (@(posedge hostClk) disable iff (!hardRstN)
    (hostWr && hostAddr == ADDR_W'(RESULT_ADDR)) |-> !strb.wrEn);
endmodule

// File: tb/sim_cfgif_host_regs.sv
`timescale 1ns/1ps
module sim_cfgif_host_regs;
  localparam int CLK_PERIOD = 10;

  logic        hostClk = 1'b0;
  logic        coreClk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        hostWr = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        hostBusy;

  cfgif_host_regs u0 (
    .hostClk(hostClk), .coreClk(coreClk), .hardRstN(hardRstN), .softRst(softRst),
    .hostWr(hostWr), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostBusy(hostBusy)
  );

  initial forever #(CLK_PERIOD/2) hostClk = ~hostClk;
  initial begin #3; forever #(CLK_PERIOD/2) coreClk = ~coreClk; end

  int nChecks = 0;
  int nErrs = 0;
  int pendCnt = 0;
  bit monEn = 0;
  int expSlave [128];
  int indMem [768];
  int indRes = 0;

  function automatic bit isReg(input int a);
    if (a >= 'h78) return a != 'h7A;
    return (a % 32) < 24;
  endfunction

  function automatic int expRead(input int a);
    if (a == 'h7A) return indRes;
    if (isReg(a)) return expSlave[a];
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 128; i++) expSlave[i] = 0;
    indRes = 0;
  endtask

  task automatic runInd(input int cmd);
    int page;
    int off;
    page = (cmd >> 8) & 3;
    off  = cmd & 255;
    if ((cmd & 'h8000) != 0) indRes = (page < 3) ? indMem[page*256 + off] : 0;
    else if (page < 3) indMem[page*256 + off] = expSlave['h79];
  endtask

  // Called at a host negedge; leaves at the following negedge
  task automatic wr(input int a, input int d);
    hostWr = 1'b1; hostAddr = 7'(a); hostWrData = 16'(d);
    pendCnt++;
    if (isReg(a)) expSlave[a] = d;
    if (a == 'h78) runInd(d);
    @(negedge hostClk);
    hostWr = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge hostClk);
    pendCnt = 0;
  endtask

  task automatic rdChk(input int a, input int exp, input string req);
    @(negedge hostClk);
    hostAddr = 7'(a);
    #2;
    chk(hostRdData == 16'(exp), req, int'(hostRdData), exp);
  endtask

  task automatic sweep();
    for (int a = 0; a < 128; a++) begin
      @(negedge hostClk);
      hostAddr = 7'(a);
    end
    @(negedge hostClk);
  endtask

  // Exact latency of readback and busy after one write
  task automatic timedWrite(input int a, input int d, input int old);
    @(negedge hostClk);
    wr(a, d);
    #2;
    for (int k = 1; k <= 6; k++) begin
      if (k == 1) chk(hostBusy == 1'b1, "R4 busy after write", int'(hostBusy), 1);
      if (k == 3) chk(hostRdData == 16'(old), "R3 old value before 4th core edge", int'(hostRdData), old);
      if (k == 4) chk(hostRdData == 16'(d), "R3 new value at 4th core edge", int'(hostRdData), d);
      if (k == 5) chk(hostBusy == 1'b1, "R4 busy until ack", int'(hostBusy), 1);
      if (k == 6) chk(hostBusy == 1'b0, "R4 busy cleared", int'(hostBusy), 0);
      if (k < 6) #(CLK_PERIOD);
    end
  endtask

  // Reference comparison on every host clock while idle
  always @(posedge hostClk) begin
    #7;
    if (monEn && pendCnt == 0) begin
      chk(hostRdData == 16'(expRead(int'(hostAddr))), "R1 R3 per-clock readback",
          int'(hostRdData), expRead(int'(hostAddr)));
      chk(hostBusy == 1'b0, "R4 idle busy", int'(hostBusy), 0);
    end
  end

  initial begin
    repeat (100000) @(posedge hostClk);
    nErrs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    clearModel();
    for (int i = 0; i < 768; i++) indMem[i] = 0;
    repeat (3) @(negedge hostClk);
    hardRstN = 1'b1;
    // R2: reset state
    rdChk('h00, 0, "R2 reset read 0x00");
    chk(hostBusy == 1'b0, "R2 reset busy", int'(hostBusy), 0);
    rdChk('h78, 0, "R2 reset read 0x78");
    monEn = 1;
    sweep();

    // R3 R4: exact latency, twice on the same word
    timedWrite('h05, 'hA5A5, 0);
    settle();
    timedWrite('h05, 'h5A5A, 'hA5A5);
    settle();
    sweep();

    // R1: unmapped writes
    @(negedge hostClk);
    wr('h18, 'h1111);
    hostAddr = 7'h18; #2;
    chk(hostBusy == 1'b0, "R1 no busy on unmapped write", int'(hostBusy), 0);
    @(negedge hostClk);
    wr('h3F, 'h2222);
    wr('h5A, 'h3333);
    settle();
    rdChk('h18, 0, "R1 unmapped 0x18 reads zero");
    rdChk('h5A, 0, "R1 unmapped 0x5A reads zero");
    rdChk('h17, 0, "R1 last channel-0 word untouched");

    // R5: back-to-back writes to different words
    @(negedge hostClk);
    wr('h20, 'h0C20);
    wr('h21, 'h0C21);
    wr('h40, 'h0C40);
    hostAddr = 7'h60; #2;
    chk(hostBusy == 1'b0, "R5 other word not busy", int'(hostBusy), 0);
    hostAddr = 7'h21; #1;
    chk(hostBusy == 1'b1, "R5 written word busy", int'(hostBusy), 1);
    settle();
    rdChk('h20, 'h0C20, "R5 first of burst");
    rdChk('h21, 'h0C21, "R5 second of burst");
    rdChk('h40, 'h0C40, "R5 third of burst");

    // R6: same-word writes while busy
    @(negedge hostClk);
    wr('h30, 'h1111);
    wr('h30, 'h2222);
    wr('h30, 'h3333);
    hostAddr = 7'h30; #2;
    #(CLK_PERIOD*7);
    chk(hostBusy == 1'b1, "R6 busy held through pending write", int'(hostBusy), 1);
    settle();
    rdChk('h30, 'h3333, "R6 last held write wins");
    sweep();

    // R8 R9: indirect round trip
    @(negedge hostClk); wr('h79, 'hBEEF); settle();
    @(negedge hostClk); wr('h78, 'h0110); settle();
    @(negedge hostClk); wr('h78, 'h8110); settle();
    rdChk('h7A, 'hBEEF, "R9 indirect read page 1");
    @(negedge hostClk); wr('h79, 'h0000); settle();
    @(negedge hostClk); wr('h78, 'hFD10); settle();
    rdChk('h7A, 'hBEEF, "R8 bits 14:10 ignored");
    @(negedge hostClk); wr('h79, 'h1234); settle();
    @(negedge hostClk); wr('h78, 'h02FF); settle();
    @(negedge hostClk); wr('h78, 'h82FF); settle();
    rdChk('h7A, 'h1234, "R9 indirect read page 2 last offset");

    // R10: unbacked page
    @(negedge hostClk); wr('h79, 'h7777); settle();
    @(negedge hostClk); wr('h78, 'h0005); settle();
    @(negedge hostClk); wr('h79, 'h5555); settle();
    @(negedge hostClk); wr('h78, 'h0305); settle();
    @(negedge hostClk); wr('h78, 'h8305); settle();
    rdChk('h7A, 0, "R10 page 3 read zero");
    @(negedge hostClk); wr('h78, 'h8005); settle();
    rdChk('h7A, 'h7777, "R10 page 0 untouched by page 3 write");

    // R11: result word is read-only
    @(negedge hostClk); wr('h7A, 'hAAAA); settle();
    rdChk('h7A, 'h7777, "R11 write to result ignored");
    sweep();

    // R7: soft reset
    monEn = 0;
    @(negedge hostClk); softRst = 1'b1;
    @(negedge hostClk); softRst = 1'b0;
    clearModel();
    repeat (3) @(negedge hostClk);
    rdChk('h05, 0, "R7 soft reset clears word");
    rdChk('h7A, 0, "R7 soft reset clears result");
    monEn = 1;
    sweep();
    timedWrite('h61, 'h4242, 0);
    settle();

    // R2: hard reset in mid-run
    monEn = 0;
    @(negedge hostClk); hardRstN = 1'b0;
    repeat (3) @(negedge hostClk);
    hardRstN = 1'b1;
    clearModel();
    rdChk('h61, 0, "R2 hard reset clears word");
    rdChk('h20, 0, "R2 hard reset clears channel 1");
    monEn = 1;
    sweep();

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule